// File: doc/BRIEF.md
# Configurable CRC Calculation Unit

This block keeps a running checksum over 32-bit words written to it through a small word-wide register bus. The generator polynomial can be 32, 16, 8 or 7 bits wide and is taken from a programmable polynomial register. A programmable start value is copied into the checksum when software writes the self-clearing reload bit. Before a word enters the calculation, it can be bit-reversed within each byte, within each halfword, or across the whole word. The checksum can also be shown bit-reversed when it is read.

A sequencer with two states drives the calculation. `ENG_IDLE` waits for a word. An accepted write to the data register moves it to `ENG_RUN` (transition *accept*). In `ENG_RUN` the engine handles 8 bits per clock. It stays in `ENG_RUN` while chunks remain (transition *step*) and returns to `ENG_IDLE` after the fourth chunk (transition *finish*). While the engine is in `ENG_RUN`, the bus holds every access with `bus_ready` low. No word is ever lost this way.

Register offsets, in bytes: checksum/data 0x00, scratch byte 0x04, control 0x08, start value 0x10, polynomial 0x14. Reads at any other offset return zero. Control fields:

| Bit(s) | Meaning |
|---|---|
| 7 | output reversal enable |
| 6:5 | input reversal: 0 none, 1 per byte, 2 per halfword, 3 whole word |
| 4:3 | polynomial width: 0 is 32, 1 is 16, 2 is 8, 3 is 7 |
| 0 | reload (write-1) |

Top module: `crc_unit`

## Requirements
- R1: After reset, the bus reads control 0x00000000, start value 0xFFFFFFFF, polynomial 0x04C11DB7, checksum 0xFFFFFFFF and scratch byte 0x00000000.
- R2: A control read returns zero in bits 31:8, 2:1 and 0. Writing 0xFFFFFFFF therefore reads back 0x000000F8.
- R3: A control write with bit 0 set copies the start value into the checksum. The other control fields of that same write take effect as written.
- R4: With width code 0, each data word is folded into the checksum most significant bit first. Each bit step computes feedback = checksum[31] XOR data bit, shifts the checksum left by one, and XORs in the polynomial when feedback is 1.
- R5: With width codes 1, 2 and 3 (16, 8 and 7 bits), the same step uses checksum bit W-1 and the low W polynomial bits. The checksum read shows zero above bit W-1.
- R6: Input reversal code 1 mirrors the bit order inside each byte, code 2 inside each halfword, and code 3 across all 32 bits. The reversal is applied before the word is processed.
- R7: With control bit 7 set, the checksum read returns the low W bits in mirrored order and zero above them.
- R8: The scratch register keeps bits 7:0 of its last write and reads zero above. Data writes, reloads and control settings never change it.
- R9: An accepted data write holds `bus_ready` low for exactly 4 cycles. An access made during that time completes once the word is done, and every word is included in the checksum.
- R10: The start value and polynomial registers read back the full 32-bit word last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_sel | input | 1 | access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | byte offset of the register |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, valid while selected and ready |
| bus_ready | output | 1 | access completes at the clock edge where this is high |

## Verification
A wrong feedback tap, mask or reversal in the engine shows up at the first checksum read after one word. The value is off from the model in bits that depend on the polynomial width and reversal mode, so every width and every reversal code is tested on its own. A sequencer that leaves `ENG_RUN` too early or too late shows up as a stall count other than 4 on the very next access. A sequencer that drops a word shows up as a wrong checksum after two back-to-back writes. A corrupted reload or scratch register is visible on the next read of the checksum or of the scratch byte.

// File: rtl/crc_pkg.sv
package crc_pkg;

    typedef enum logic [1:0] {
        PW_32 = 2'd0,
        PW_16 = 2'd1,
        PW_8  = 2'd2,
        PW_7  = 2'd3
    } poly_w_e;

    typedef enum logic [1:0] {
        IR_NONE = 2'd0,
        IR_BYTE = 2'd1,
        IR_HALF = 2'd2,
        IR_WORD = 2'd3
    } in_rev_e;

    typedef struct packed {
        logic    out_rev;
        in_rev_e in_rev;
        poly_w_e pw;
    } ctl_t;

    localparam int DW = 32;

    function automatic logic [DW-1:0] width_mask(poly_w_e pw);
        case (pw)
            PW_32:   return 32'hFFFF_FFFF;
            PW_16:   return 32'h0000_FFFF;
            PW_8:    return 32'h0000_00FF;
            default: return 32'h0000_007F;
        endcase
    endfunction

    function automatic logic [4:0] top_bit(poly_w_e pw);
        case (pw)
            PW_32:   return 5'd31;
            PW_16:   return 5'd15;
            PW_8:    return 5'd7;
            default: return 5'd6;
        endcase
    endfunction

    // shift that aligns a 32-bit mirror back to the low W bits
    function automatic logic [4:0] mirror_shift(poly_w_e pw);
        case (pw)
            PW_32:   return 5'd0;
            PW_16:   return 5'd16;
            PW_8:    return 5'd24;
            default: return 5'd25;
        endcase
    endfunction

    // one MSB-first shift-and-XOR step
    function automatic logic [DW-1:0] crc_bit(logic [DW-1:0] crc, logic din,
                                              logic [DW-1:0] poly, poly_w_e pw);
        logic          fb;
        logic [DW-1:0] nxt;
        fb  = crc[top_bit(pw)] ^ din;
        nxt = crc << 1;
        if (fb) nxt = nxt ^ poly;
        return nxt & width_mask(pw);
    endfunction

endpackage

// File: rtl/crc_regs.sv
module crc_regs
    import crc_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int FREE_W     = 8,
    parameter logic [31:0] IDATA_RST = 32'hFFFF_FFFF,
    parameter logic [31:0] POLY_RST  = 32'h04C1_1DB7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output ctl_t              ctl,
    output logic [31:0]       idata,
    output logic [31:0]       poly,
    output logic [FREE_W-1:0] free_q,
    output logic              reload,
    output logic              data_wr
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(5'h00);
    localparam logic [ADDR_W-1:0] A_FREE = ADDR_W'(5'h04);
    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(5'h08);
    localparam logic [ADDR_W-1:0] A_INIT = ADDR_W'(5'h10);
    localparam logic [ADDR_W-1:0] A_POLY = ADDR_W'(5'h14);

    always_comb begin
        reload  = wr_en && (addr == A_CTL) && wdata[0];
        data_wr = wr_en && (addr == A_DATA);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl    <= '0;
            idata  <= IDATA_RST;
            poly   <= POLY_RST;
            free_q <= '0;
        end else if (wr_en) begin
            unique case (addr)
                A_CTL:   ctl    <= ctl_t'(wdata[7:3]);
                A_INIT:  idata  <= wdata;
                A_POLY:  poly   <= wdata;
                A_FREE:  free_q <= wdata[FREE_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/crc_swap.sv
module crc_swap
    import crc_pkg::*;
(
    input  logic [31:0] din,
    input  in_rev_e     in_rev,
    input  logic [31:0] crc,
    input  poly_w_e     pw,
    input  logic        out_rev,
    output logic [31:0] din_r,
    output logic [31:0] crc_r
);
    localparam int NB = 4;
    localparam int NH = 2;

    logic [31:0] by_rev, hw_rev, wd_rev, crc_m, crc_mir;

    for (genvar g = 0; g < NB; g++) begin : g_byte
        for (genvar k = 0; k < 8; k++) begin : g_bit
            assign by_rev[g*8+k] = din[g*8+7-k];
        end
    end

    for (genvar g = 0; g < NH; g++) begin : g_half
        for (genvar k = 0; k < 16; k++) begin : g_bit
            assign hw_rev[g*16+k] = din[g*16+15-k];
        end
    end

    for (genvar k = 0; k < 32; k++) begin : g_word
        assign wd_rev[k]  = din[31-k];
        assign crc_mir[k] = crc_m[31-k];
    end

    always_comb begin
        unique case (in_rev)
            IR_NONE: din_r = din;
            IR_BYTE: din_r = by_rev;
            IR_HALF: din_r = hw_rev;
            IR_WORD: din_r = wd_rev;
        endcase
    end

    always_comb begin
        crc_m = crc & width_mask(pw);
        crc_r = out_rev ? (crc_mir >> mirror_shift(pw)) : crc_m;
    end

endmodule

// File: rtl/crc_engine.sv
module crc_engine
    import crc_pkg::*;
#(
    parameter int          BPC      = 8,
    parameter logic [31:0] CRC_RST  = 32'hFFFF_FFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] word,
    input  logic        load,
    input  logic [31:0] load_val,
    input  poly_w_e     pw,
    input  logic [31:0] poly,
    output logic        busy,
    output logic [31:0] crc
);
    localparam int STEPS = DW / BPC;
    localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    typedef enum logic {ENG_IDLE, ENG_RUN} eng_st_e;

    eng_st_e       st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic [31:0]   sh_q;
    logic [31:0]   chunk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ENG_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ENG_IDLE: if (start)         st_d = ENG_RUN;
            ENG_RUN:  if (cnt_q == LAST) st_d = ENG_IDLE;
        endcase
    end

    always_comb begin
        busy = (st_q == ENG_RUN);
    end

    always_comb begin
        chunk = crc;
        for (int i = 0; i < BPC; i++) begin
            chunk = crc_bit(chunk, sh_q[DW-1-i], poly, pw);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc   <= CRC_RST;
            sh_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (load) crc <= load_val;
            unique case (st_q)
                ENG_IDLE: if (start) begin
                    sh_q  <= word;
                    cnt_q <= '0;
                end
                ENG_RUN: begin
                    crc   <= chunk;
                    sh_q  <= sh_q << BPC;
                    cnt_q <= cnt_q + 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/crc_unit.sv
module crc_unit
    import crc_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int BPC    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ready
);
    localparam int          FREE_W    = 8;
    localparam logic [31:0] IDATA_RST = 32'hFFFF_FFFF;

    ctl_t              ctl;
    logic [31:0]       idata_q, poly_q, crc_q, din_r, crc_rd;
    logic [FREE_W-1:0] free_q;
    logic              reload, data_wr, busy, wr_en;
    logic [1:0]        ctl_pw_bits;

    assign bus_ready   = !busy;
    assign wr_en       = bus_sel && bus_wr && bus_ready;
    assign ctl_pw_bits = ctl.pw;

    crc_regs #(
        .ADDR_W(ADDR_W), .FREE_W(FREE_W),
        .IDATA_RST(IDATA_RST), .POLY_RST(32'h04C1_1DB7)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr),
        .wdata(bus_wdata), .ctl(ctl), .idata(idata_q), .poly(poly_q),
        .free_q(free_q), .reload(reload), .data_wr(data_wr)
    );

    crc_swap u_swap (
        .din(bus_wdata), .in_rev(ctl.in_rev), .crc(crc_q), .pw(ctl.pw),
        .out_rev(ctl.out_rev), .din_r(din_r), .crc_r(crc_rd)
    );

    crc_engine #(.BPC(BPC), .CRC_RST(IDATA_RST)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(data_wr), .word(din_r),
        .load(reload), .load_val(idata_q), .pw(ctl.pw), .poly(poly_q),
        .busy(busy), .crc(crc_q)
    );

    always_comb begin
        unique case (bus_addr)
            ADDR_W'(5'h00): bus_rdata = crc_rd;
            ADDR_W'(5'h04): bus_rdata = {{(32-FREE_W){1'b0}}, free_q};
            ADDR_W'(5'h08): bus_rdata = {24'b0, ctl, 3'b000};
            ADDR_W'(5'h10): bus_rdata = idata_q;
            ADDR_W'(5'h14): bus_rdata = poly_q;
            default:        bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/crc_unit_chk.sv
module crc_unit_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              bus_ready,
    input logic [1:0]        ctl_pw,
    input logic [31:0]       crc_q,
    input logic [31:0]       idata_q
);
    assert_ctl_rsvd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr == ADDR_W'(5'h08)) |->
            (bus_rdata[31:8] == 24'b0 && bus_rdata[2:0] == 3'b0));

    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_ready && bus_addr == ADDR_W'(5'h08) && bus_wdata[0])
            |=> (crc_q == $past(idata_q)));

    assert_width_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr == ADDR_W'(5'h00) && ctl_pw != 2'd0) |->
            (bus_rdata[31:16] == 16'b0));

    assert_free_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr == ADDR_W'(5'h04)) |-> (bus_rdata[31:8] == 24'b0));

    assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_ready && bus_addr == ADDR_W'(5'h00)) |=> !bus_ready);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready |=> $stable(idata_q));

endmodule

bind crc_unit crc_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .ctl_pw(ctl_pw_bits), .crc_q(crc_q),
    .idata_q(idata_q)
);

// File: tb/crc_unit_tb.sv
module crc_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;

    int errors = 0;
    int checks = 0;
    int stalls = 0;
    bit done = 0;

    logic [31:0] m_crc;
    int          m_w;
    int          m_ir;
    bit          m_or;
    logic [31:0] m_poly;

    always #5 clk = ~clk;

    crc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_xfer(bit wr, logic [4:0] a, logic [31:0] d, output logic [31:0] rd);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        stalls = 0;
        #1;
        while (!bus_ready) begin
            @(negedge clk); stalls++; #1;
        end
        rd = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        logic [31:0] unused;
        bus_xfer(1'b1, a, d, unused);
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] v);
        bus_xfer(1'b0, a, 32'h0, v);
    endtask

    function automatic logic [31:0] m_mask(int w);
        return (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    endfunction

    function automatic logic [31:0] m_inrev(logic [31:0] x, int mode);
        logic [31:0] y;
        for (int k = 0; k < 32; k++) begin
            case (mode)
                1: y[k] = x[(k/8)*8 + 7 - (k%8)];
                2: y[k] = x[(k/16)*16 + 15 - (k%16)];
                3: y[k] = x[31-k];
                default: y[k] = x[k];
            endcase
        end
        return y;
    endfunction

    function automatic logic [31:0] m_expect();
        logic [31:0] c, y;
        c = m_crc & m_mask(m_w);
        y = '0;
        if (!m_or) return c;
        for (int k = 0; k < m_w; k++) y[k] = c[m_w-1-k];
        return y;
    endfunction

    task automatic m_word(logic [31:0] d);
        logic [31:0] x;
        logic        fb;
        x = m_inrev(d, m_ir);
        for (int i = 31; i >= 0; i--) begin
            fb    = m_crc[m_w-1] ^ x[i];
            m_crc = (m_crc << 1) & m_mask(m_w);
            if (fb) m_crc = m_crc ^ (m_poly & m_mask(m_w));
        end
    endtask

    task automatic setup(int pwc, int ir, bit orv, logic [31:0] poly, logic [31:0] init);
        wr(5'h14, poly);
        wr(5'h10, init);
        wr(5'h08, {24'b0, orv, 2'(ir), 2'(pwc), 3'b001});
        m_w    = (pwc == 0) ? 32 : (pwc == 1) ? 16 : (pwc == 2) ? 8 : 7;
        m_ir   = ir; m_or = orv; m_poly = poly; m_crc = init;
    endtask

    task automatic feed(logic [31:0] d);
        wr(5'h00, d);
        m_word(d);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(5'h08, v); check("R1 ctl", v, 32'h0);
        rd(5'h10, v); check("R1 init", v, 32'hFFFF_FFFF);
        rd(5'h14, v); check("R1 poly", v, 32'h04C1_1DB7);
        rd(5'h00, v); check("R1 data", v, 32'hFFFF_FFFF);
        rd(5'h04, v); check("R1 free", v, 32'h0);
    endtask

    task automatic t_ctl();
        logic [31:0] v;
        wr(5'h08, 32'hFFFF_FFFF);
        rd(5'h08, v); check("R2 ctl reserved", v, 32'h0000_00F8);
        wr(5'h08, 32'h0);
        rd(5'h08, v); check("R2 ctl clear", v, 32'h0);
    endtask

    task automatic t_reload();
        logic [31:0] v;
        setup(0, 0, 0, 32'h04C1_1DB7, 32'h1234_ABCD);
        rd(5'h00, v); check("R3 reload", v, 32'h1234_ABCD);
        feed(32'h0000_0001);
        wr(5'h08, 32'h1);
        rd(5'h00, v); check("R3 reload again", v, 32'h1234_ABCD);
        wr(5'h08, 32'h0000_0011);
        rd(5'h08, v); check("R3 fields kept", v, 32'h0000_0010);
    endtask

    task automatic t_crc32();
        logic [31:0] v;
        setup(0, 0, 0, 32'h04C1_1DB7, 32'hFFFF_FFFF);
        feed(32'h1234_5678);
        rd(5'h00, v); check("R4 one word", v, m_expect());
        feed(32'hDEAD_BEEF);
        feed(32'h0000_0000);
        rd(5'h00, v); check("R4 three words", v, m_expect());
    endtask

    task automatic t_widths();
        logic [31:0] v;
        setup(1, 0, 0, 32'hABCD_1021, 32'hFFFF_FFFF);
        feed(32'hCAFE_F00D);
        rd(5'h00, v); check("R5 width 16", v, m_expect());
        setup(2, 0, 0, 32'hFFFF_FF07, 32'h0000_0000);
        feed(32'h0102_0304); feed(32'hA5A5_5A5A);
        rd(5'h00, v); check("R5 width 8", v, m_expect());
        setup(3, 0, 0, 32'h0000_0009, 32'h0000_007F);
        feed(32'h8000_0001);
        rd(5'h00, v); check("R5 width 7", v, m_expect());
        rd(5'h14, v); check("R10 poly readback", v, 32'h0000_0009);
        rd(5'h10, v); check("R10 init readback", v, 32'h0000_007F);
    endtask

    task automatic t_inrev();
        logic [31:0] v;
        for (int m = 1; m < 4; m++) begin
            setup(0, m, 0, 32'h04C1_1DB7, 32'hFFFF_FFFF);
            feed(32'h0123_4567);
            rd(5'h00, v); check($sformatf("R6 in-rev mode %0d", m), v, m_expect());
        end
    endtask

    task automatic t_outrev();
        logic [31:0] v;
        setup(0, 3, 1, 32'h04C1_1DB7, 32'hFFFF_FFFF);
        feed(32'h3132_3334);
        rd(5'h00, v); check("R7 out-rev 32", v, m_expect());
        setup(1, 0, 1, 32'h0000_8005, 32'h0000_0001);
        feed(32'h0000_00FF);
        rd(5'h00, v); check("R7 out-rev 16", v, m_expect());
        setup(3, 0, 1, 32'h0000_0009, 32'h0000_0001);
        rd(5'h00, v); check("R7 out-rev 7 after reload", v, 32'h0000_0040);
    endtask

    task automatic t_free();
        logic [31:0] v;
        wr(5'h04, 32'hFFFF_FFA5);
        rd(5'h04, v); check("R8 free write", v, 32'h0000_00A5);
        setup(0, 2, 1, 32'h04C1_1DB7, 32'h0);
        feed(32'h5555_AAAA);
        wr(5'h08, 32'h0);
        rd(5'h04, v); check("R8 free untouched", v, 32'h0000_00A5);
    endtask

    task automatic t_stall();
        logic [31:0] v;
        setup(0, 0, 0, 32'h04C1_1DB7, 32'hFFFF_FFFF);
        feed(32'hAAAA_0000);
        wr(5'h00, 32'h0000_5555); m_word(32'h0000_5555);
        check("R9 stall cycles", 32'(stalls), 32'd4);
        rd(5'h00, v); check("R9 no word dropped", v, m_expect());
        check("R9 read stall", 32'(stalls), 32'd4);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctl();
        t_reload();
        t_crc32();
        t_widths();
        t_inrev();
        t_outrev();
        t_free();
        t_stall();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule